// File: doc/BRIEF.md
# Converter Output Formatter with Overrange Flag

This block takes the corrected 14-bit word of a pipelined data converter and prepares it for the output pins. Each word is sampled on the rising clock edge and passes through a short pipeline of `DEPTH` rising-edge stages. The output register is loaded on the falling edge, so the pins are stable while the clock is high. On the way out the word is coded either as straight binary or as two's complement, depending on a format-select input. Only the most significant bit differs between the two codings. An overrange flag is raised when the word sits at either end of the scale.

A data-ready strobe reproduces the clock once valid words are flowing. Its rising edge falls in the middle of each stable data window, so downstream logic can capture on it. An active-high output-disable input takes all pins into high impedance: the data bus, the flag and the strobe. The pipeline keeps converting while the pins are off, so the word seen after the pins come back is the current one and not a stale one. High impedance is modelled as `'z` on the pad ports, together with an explicit enable per pin.

A four-state machine runs on the falling edge and governs the pins.
- States:
  - `ST_FILL_ON`: pipeline not yet full, pins driven.
  - `ST_FILL_OFF`: pipeline not yet full, pins off.
  - `ST_RUN_ON`: words flowing, pins driven.
  - `ST_RUN_OFF`: words flowing, pins off.
- Transitions:
  - *arrive*: from a FILL state to the RUN state of the same enable, taken when the pipeline tail first holds a valid word.
  - *mute*: from an ON state to the OFF state of the same phase, taken when the disable input is high at a falling edge.
  - *unmute*: the reverse of *mute*, taken when the disable input is low at a falling edge.
  - When *arrive* and *mute* (or *unmute*) occur at the same edge, both apply together.
- Reset enters `ST_FILL_ON`.

Top module: `adc_out_formatter`

## Requirements
- R1: While reset is asserted, and afterwards until the first word reaches the output register, `data_pad`, `ovr_pad` and `rdy_pad` read 0. After reset and until the first falling edge with `out_dis` high, all enables read 1.
- R2: A word sampled on rising edge k is loaded into the output at the falling edge that follows rising edge k+DEPTH-1. With the default DEPTH=2, this is the falling edge after the next rising edge.
- R3: With `fmt_sel`=1, `data_pad` equals the sampled word. With `fmt_sel`=0, bit 13 of `data_pad` is the complement of bit 13 of the sampled word (two's complement). In both codings, bits 12:0 are unchanged.
- R4: `ovr_pad` is 1 exactly when the sampled word is 14'h0000 or 14'h3FFF, whatever the value of `fmt_sel`.
- R5: `fmt_sel` is taken only at the falling edge that loads a word. A change of `fmt_sel` between loads leaves the word on the pins unchanged.
- R6: If `out_dis` is 1 at a falling edge, every enable (`data_oe`, `ovr_oe`, `rdy_oe`) drops to 0 at that edge and the pads go to 'z. If `out_dis` is 0 at a falling edge, every enable is 1 from that edge on.
- R7: Sampling and loading continue while the pins are disabled. When the pins are re-enabled, they show the word loaded at the re-enabling edge.
- R8: Once the first word has been loaded and the pins are enabled, `rdy_pad` follows the clock: it is 1 while `clk` is high and 0 while `clk` is low. Before the first word, it stays 0.
- R9: The 14 bits of `data_oe` all equal the group enable and equal `ovr_oe` and `rdy_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock: words are sampled on the rising edge and the output is loaded on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 14 | Corrected converter word, straight binary |
| fmt_sel | input | 1 | 1 = straight binary, 0 = two's complement |
| out_dis | input | 1 | 1 = all outputs in high impedance |
| data_pad | output | 14 | Formatted data bus, 'z when disabled |
| ovr_pad | output | 1 | Overrange flag, 'z when disabled |
| rdy_pad | output | 1 | Data-ready strobe, 'z when disabled |
| data_oe | output | 14 | Per-pin enables of the data bus |
| ovr_oe | output | 1 | Enable of the flag pin |
| rdy_oe | output | 1 | Enable of the strobe pin |

## Verification
Several events can fall on a single falling edge: a word load together with a change of pin enable, and a format change together with an end-of-scale word. The bench provokes both by driving a new `out_dis` value, a new `fmt_sel` value and full-scale or zero words in the same cycle, in both directions of the enable. A behavioural queue model predicts the output of every edge. Values are compared only while the model expects the pins to be driven, and the enables are compared on every edge, so a load lost or frozen during a disabled stretch shows up at the first enabled cycle.

// File: rtl/aof_pkg.sv
package aof_pkg;
    typedef enum logic [1:0] {
        ST_FILL_ON  = 2'b00,
        ST_FILL_OFF = 2'b01,
        ST_RUN_ON   = 2'b10,
        ST_RUN_OFF  = 2'b11
    } pin_state_t;

    function automatic logic is_run(input pin_state_t s);
        return (s == ST_RUN_ON) || (s == ST_RUN_OFF);
    endfunction

    function automatic logic is_on(input pin_state_t s);
        return (s == ST_FILL_ON) || (s == ST_RUN_ON);
    endfunction
endpackage

// File: rtl/aof_sample_pipe.sv
module aof_sample_pipe #(
    parameter int W     = 14,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] tail_word,
    output logic         tail_valid
);
    logic [DEPTH-1:0][W-1:0] stg;
    logic [DEPTH-1:0]        vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
            vld[0] <= 1'b0;
        end else begin
            stg[0] <= din;
            vld[0] <= 1'b1;
        end
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[i] <= '0;
                vld[i] <= 1'b0;
            end else begin
                stg[i] <= stg[i-1];
                vld[i] <= vld[i-1];
            end
        end
    end

    assign tail_word  = stg[DEPTH-1];
    assign tail_valid = vld[DEPTH-1];
endmodule

// File: rtl/aof_word_coder.sv
module aof_word_coder #(
    parameter int W = 14
) (
    input  logic [W-1:0] raw,
    input  logic         fmt_sel,
    output logic [W-1:0] coded,
    output logic         at_edge
);
    localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

    always_comb begin
        coded        = raw;
        coded[W-1]   = raw[W-1] ^ ~fmt_sel;
        at_edge      = (raw == '0) || (raw == ALL_ONE);
    end
endmodule

// File: rtl/aof_out_seq.sv
module aof_out_seq
    import aof_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tail_valid,
    input  logic [W-1:0] coded,
    input  logic         at_edge,
    input  logic         out_dis,
    output logic [W-1:0] data_q,
    output logic         ovr_q,
    output pin_state_t   state,
    output logic         grp_oe,
    output logic         armed
);
    pin_state_t nxt;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_FILL_ON;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FILL_ON, ST_FILL_OFF: begin
                if (tail_valid) nxt = out_dis ? ST_RUN_OFF  : ST_RUN_ON;
                else            nxt = out_dis ? ST_FILL_OFF : ST_FILL_ON;
            end
            ST_RUN_ON, ST_RUN_OFF: begin
                nxt = out_dis ? ST_RUN_OFF : ST_RUN_ON;
            end
            default: nxt = ST_FILL_ON;
        endcase
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else if (tail_valid) begin
            data_q <= coded;
            ovr_q  <= at_edge;
        end
    end

    always_comb begin
        grp_oe = is_on(state);
        armed  = is_run(state);
    end
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
    import aof_pkg::*;
#(
    parameter int W     = 14,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_in,
    input  logic         fmt_sel,
    input  logic         out_dis,
    output logic [W-1:0] data_pad,
    output logic         ovr_pad,
    output logic         rdy_pad,
    output logic [W-1:0] data_oe,
    output logic         ovr_oe,
    output logic         rdy_oe
);
    logic [W-1:0] tail_word;
    logic         tail_valid;
    logic [W-1:0] coded;
    logic         at_edge;
    logic [W-1:0] data_q;
    logic         ovr_q;
    pin_state_t   state;
    logic         grp_oe;
    logic         armed;

    aof_sample_pipe #(.W(W), .DEPTH(DEPTH)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .din        (data_in),
        .tail_word  (tail_word),
        .tail_valid (tail_valid)
    );

    aof_word_coder #(.W(W)) u_coder (
        .raw     (tail_word),
        .fmt_sel (fmt_sel),
        .coded   (coded),
        .at_edge (at_edge)
    );

    aof_out_seq #(.W(W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tail_valid (tail_valid),
        .coded      (coded),
        .at_edge    (at_edge),
        .out_dis    (out_dis),
        .data_q     (data_q),
        .ovr_q      (ovr_q),
        .state      (state),
        .grp_oe     (grp_oe),
        .armed      (armed)
    );

    for (genvar b = 0; b < W; b++) begin : g_pin
        assign data_oe[b]  = grp_oe;
        assign data_pad[b] = grp_oe ? data_q[b] : 1'bz;
    end

    assign ovr_oe  = grp_oe;
    assign rdy_oe  = grp_oe;
    assign ovr_pad = grp_oe ? ovr_q : 1'bz;
    assign rdy_pad = grp_oe ? (clk & armed) : 1'bz;
endmodule

// File: rtl/aof_checker.sv
module aof_checker
    import aof_pkg::*;
#(
    parameter int W = 14
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] tail_word,
    input logic         tail_valid,
    input logic         fmt_sel,
    input logic         out_dis,
    input logic [W-1:0] data_q,
    input logic         ovr_q,
    input pin_state_t   state,
    input logic         grp_oe,
    input logic         armed
);
    // R4
    ovr_flag_chk: assert property (@(negedge clk) disable iff (!rst_n)
        tail_valid |=> (ovr_q == (($past(tail_word) == '0) || (&$past(tail_word)))));

    // R3
    msb_code_chk: assert property (@(negedge clk) disable iff (!rst_n)
        tail_valid |=> (data_q[W-1] == ($past(tail_word[W-1]) ^ !$past(fmt_sel))));

    // R3
    low_bits_chk: assert property (@(negedge clk) disable iff (!rst_n)
        tail_valid |=> (data_q[W-2:0] == $past(tail_word[W-2:0])));

    // R6
    pin_enable_chk: assert property (@(negedge clk) disable iff (!rst_n)
        1'b1 |=> (grp_oe == !$past(out_dis)));

    // R1
    fill_quiet_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !armed |-> (data_q == '0 && !ovr_q));

    // R7
    run_sticky_chk: assert property (@(negedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

bind adc_out_formatter aof_checker #(.W(W)) u_aof_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tail_word  (tail_word),
    .tail_valid (tail_valid),
    .fmt_sel    (fmt_sel),
    .out_dis    (out_dis),
    .data_q     (data_q),
    .ovr_q      (ovr_q),
    .state      (state),
    .grp_oe     (grp_oe),
    .armed      (armed)
);

// File: tb/test_adc_out_formatter.sv
`timescale 1ns/1ps
module test_adc_out_formatter;
    localparam int W     = 14;
    localparam int DEPTH = 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] data_in;
    logic         fmt_sel;
    logic         out_dis;
    wire  [W-1:0] data_pad;
    wire          ovr_pad;
    wire          rdy_pad;
    wire  [W-1:0] data_oe;
    wire          ovr_oe;
    wire          rdy_oe;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    logic [W-1:0] hist[$];
    logic [W-1:0] cur_d;
    logic [W-1:0] exp_data;
    logic         exp_ovr;
    logic         exp_armed;
    logic         exp_oe;

    always #5 clk = ~clk;

    adc_out_formatter #(.W(W), .DEPTH(DEPTH)) i_adc_out_formatter (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .fmt_sel(fmt_sel),
        .out_dis(out_dis), .data_pad(data_pad), .ovr_pad(ovr_pad),
        .rdy_pad(rdy_pad), .data_oe(data_oe), .ovr_oe(ovr_oe), .rdy_oe(rdy_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_miss++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic chk_oe(input string req);
        chk(req, {16'd0, data_oe, ovr_oe, rdy_oe}, {16'd0, {W{exp_oe}}, exp_oe, exp_oe});
    endtask

    task automatic do_reset();
        @(posedge clk);
        #2 rst_n = 1'b0;
        hist.delete();
        exp_data = '0; exp_ovr = 1'b0; exp_armed = 1'b0; exp_oe = 1'b1;
        #1;
        chk("R1 data in reset", data_pad, 0);
        chk("R1 flag in reset", ovr_pad, 0);
        chk("R1 ready in reset", rdy_pad, 0);
        chk_oe("R1 enables in reset");
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        exp_oe = !out_dis;
        #1 chk_oe("R1 enables after release");
    endtask

    task automatic step(input logic [W-1:0] d, input logic f, input logic dis);
        logic [W-1:0] t;
        @(posedge clk);
        hist.push_back(cur_d);
        #1;
        chk_oe("R9 enables high phase");
        if (exp_oe) chk("R8 ready high phase", rdy_pad, exp_armed);
        #1;
        data_in = d; fmt_sel = f; out_dis = dis; cur_d = d;
        #1;
        if (exp_oe) chk("R5 word held between loads", data_pad, exp_data);
        if (hist.size() >= DEPTH) begin
            t         = hist[hist.size() - DEPTH];
            exp_data  = {t[W-1] ^ ~f, t[W-2:0]};
            exp_ovr   = (t == '0) || (t == {W{1'b1}});
            exp_armed = 1'b1;
        end
        exp_oe = !dis;
        @(negedge clk);
        #1;
        chk_oe("R6 enables follow disable");
        if (exp_oe) begin
            chk("R2 R3 R7 data word", data_pad, exp_data);
            chk("R4 overrange flag", ovr_pad, exp_ovr);
            chk("R8 ready low phase", rdy_pad, 0);
            if (!exp_armed) chk("R1 zero before first word", data_pad, 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_vec++; n_miss++;
            $display("FAIL R1-watchdog run did not finish actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; data_in = '0; fmt_sel = 1'b1; out_dis = 1'b0; cur_d = '0;
        exp_data = '0; exp_ovr = 1'b0; exp_armed = 1'b0; exp_oe = 1'b1;
        do_reset();
        // R2 fill latency, straight binary
        step(14'h1234, 1, 0);
        step(14'h0ABC, 1, 0);
        step(14'h3FFF, 1, 0);
        step(14'h0000, 1, 0);
        // R3 two's complement, R4 flag independent of format
        step(14'h2000, 0, 0);
        step(14'h1FFF, 0, 0);
        step(14'h3FFF, 0, 0);
        step(14'h0000, 0, 0);
        step(14'h0001, 0, 0);
        // R5 format toggling every cycle
        for (int i = 0; i < 8; i++) step(14'(i * 14'h0731 + 14'h2005), 1'(i[0]), 0);
        // R6 R7 disable with words and format changing underneath
        step(14'h3FFF, 0, 1);
        step(14'h0555, 1, 1);
        step(14'h2AAA, 0, 1);
        step(14'h0000, 1, 1);
        step(14'h3FFE, 0, 0);
        step(14'h0002, 1, 1);
        step(14'h3FFF, 0, 0);
        step(14'h1000, 1, 0);
        // R1 reset mid-stream, disabled during fill
        do_reset();
        step(14'h0000, 0, 1);
        step(14'h3FFF, 1, 0);
        step(14'h0123, 0, 0);
        step(14'h3210, 1, 0);
        for (int i = 0; i < 20; i++) step(14'(i * 14'h0ACE), 1'(i % 3 == 0), 1'(i % 5 == 4));
        step(14'h0000, 1, 0);
        step(14'h0000, 1, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule